// File: doc/BRIEF.md
# Eight-bit timer/counter with compare-clear and compare output

An up-counting timer that advances one step on each cycle where its count-enable tick is high. A three-bit waveform selector picks between free-running operation and compare-clear operation. Free-running operation wraps from the maximum count to zero. Compare-clear operation returns the counter to zero on the tick after it equals the compare value, so that value sets the period.

A sticky overflow flag records every wrap from the maximum count to zero. A sticky match flag records every compare hit, and it drives an interrupt request when its enable is high. A compare output unit drives one waveform pin. At each compare hit the pin is set, cleared or toggled, or it is disconnected. The action code is taken into the unit only at a hit or at a force strobe. A force strobe applies the action at once, without touching the flags or the counter. Software can load the counter directly at any time.

Top module: `tmr8_ctc`

## Requirements
- R1: After reset, count_o is 0, ovf_flag_o and match_flag_o are 0, and wave_o is 0.
- R2: The counter changes only on cycles with tick_i high (or a load). A wave_mode_i value other than 2 selects free-running operation: the counter increments, wraps from 0xFF to 0x00, and never clears on a compare hit.
- R3: ovf_flag_o rises on the tick that takes the counter from 0xFF to 0x00. It stays set until ovf_clr_i is high, and a set on the same cycle as the clear wins.
- R4: With wave_mode_i = 2, a tick taken while count_o equals cmp_val_i (and the hit is not suppressed) loads 0 into the counter.
- R5: A tick taken while count_o equals cmp_val_i sets match_flag_o in every mode. The flag is cleared by match_clr_i, a set wins over a clear on the same cycle, and match_irq_o is match_flag_o AND match_ie_i.
- R6: At a compare hit, out_mode_i selects the pin action: 0 disconnects the pin (wave_o reads 0), 1 toggles it, 2 drives it low, and 3 drives it high.
- R7: A change of out_mode_i has no effect on wave_o until the next compare hit or force strobe.
- R8: A one-cycle force_i pulse applies the out_mode_i action to the pin on that cycle. It does not set match_flag_o and does not change the counter, even in compare-clear operation.
- R9: cnt_wr_i loads cnt_wdata_i and takes priority over a tick on the same cycle. A compare hit on the first tick after a load is suppressed: no flag, no pin action and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one step per high cycle |
| wave_mode_i | input | 3 | Waveform selector: 2 = compare-clear, otherwise free-running |
| out_mode_i | input | 2 | Pin action: 0 off, 1 toggle, 2 low, 3 high |
| cmp_val_i | input | 8 | Compare value |
| force_i | input | 1 | Force compare strobe |
| cnt_wr_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | 8 | Counter load value |
| ovf_clr_i | input | 1 | Overflow flag clear (acknowledge or software) |
| match_clr_i | input | 1 | Match flag clear (acknowledge or software) |
| match_ie_i | input | 1 | Match interrupt enable |
| count_o | output | 8 | Counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| match_flag_o | output | 1 | Sticky compare-match flag |
| match_irq_o | output | 1 | Match interrupt request |
| wave_o | output | 1 | Compare output pin |

## Verification
The bench loads the counter just below the wrap point and steps it with gaps in the tick, so a counter that ignored the enable or a flag that fired one tick early shows up at once. It changes the pin action code between hits to catch a unit that applies the new code straight away. It fires force strobes while the counter sits on the compare value, which exposes a force that sets the flag or clears the counter. It loads the compare value into the counter to catch a design that fails to suppress the hit, or lets a tick win over a load. A clear that collides with a set is also exercised: a design that lets the clear win drops the event.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    ACT_OFF    = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } cmp_act_e;

  localparam int unsigned MODE_W   = 3;
  localparam logic [MODE_W-1:0] WAVE_CTC = 3'd2;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ctc_i,
  input  logic [W-1:0] cmp_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         supp_q;
  logic         step;

  assign step   = tick_i && !wr_i;
  assign hit_o  = step && !supp_q && (cnt_q == cmp_i);
  assign wrap_o = step && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      supp_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q  <= wdata_i;
      supp_q <= 1'b1;
    end else if (tick_i) begin
      supp_q <= 1'b0;
      cnt_q  <= (ctc_i && hit_o) ? '0 : cnt_q + 1'b1;
    end
  end

  assert_wr_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));

  assert_ctc_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctc_i && tick_i && !wr_i && !supp_q && cnt_q == cmp_i) |=> cnt_q == '0);
endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // sticky behaviour, covers R3 and R5
  assert_flag_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  assert_flag_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/tmr8_cmp_out.sv
module tmr8_cmp_out
  import tmr8_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hit_i,
  input  logic     force_i,
  input  cmp_act_e mode_i,
  output logic     wave_o
);
  cmp_act_e act_q;
  logic     oc_q;
  logic     oc_d;
  logic     apply;

  assign apply = hit_i || force_i;

  always_comb begin
    unique case (mode_i)
      ACT_TOGGLE: oc_d = ~oc_q;
      ACT_CLEAR:  oc_d = 1'b0;
      ACT_SET:    oc_d = 1'b1;
      default:    oc_d = oc_q;
    endcase
  end

  // action code latched only when applied
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= ACT_OFF;
      oc_q  <= 1'b0;
    end else if (apply) begin
      act_q <= mode_i;
      oc_q  <= oc_d;
    end
  end

  assign wave_o = oc_q && (act_q != ACT_OFF);

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !force_i) |=> $stable(wave_o));

  assert_set_action_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && mode_i == ACT_SET) |=> wave_o);
endmodule

// File: rtl/tmr8_ctc.sv
module tmr8_ctc
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [2:0]       wave_mode_i,
  input  logic [1:0]       out_mode_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             force_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ovf_clr_i,
  input  logic             match_clr_i,
  input  logic             match_ie_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             match_flag_o,
  output logic             match_irq_o,
  output logic             wave_o
);
  logic ctc;
  logic hit;
  logic wrap;

  assign ctc = (wave_mode_i == WAVE_CTC);

  tmr8_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .ctc_i   (ctc),
    .cmp_i   (cmp_val_i),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .cnt_o   (count_o),
    .hit_o   (hit),
    .wrap_o  (wrap)
  );

  tmr8_flag u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wrap),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_flag_o)
  );

  tmr8_flag u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (match_clr_i),
    .flag_o (match_flag_o)
  );

  tmr8_cmp_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .force_i (force_i),
    .mode_i  (cmp_act_e'(out_mode_i)),
    .wave_o  (wave_o)
  );

  assign match_irq_o = match_flag_o && match_ie_i;

  assert_force_no_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !hit && !match_flag_o) |=> !match_flag_o);

  assert_force_no_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !tick_i && !cnt_wr_i) |=> $stable(count_o));
endmodule

// File: tb/tmr8_ctc_tb_top.sv
`timescale 1ns/1ps
module tmr8_ctc_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] wave_mode_i = 3'd0;
  logic [1:0] out_mode_i = 2'd0;
  logic [7:0] cmp_val_i = 8'd0;
  logic       force_i = 1'b0;
  logic       cnt_wr_i = 1'b0;
  logic [7:0] cnt_wdata_i = 8'd0;
  logic       ovf_clr_i = 1'b0;
  logic       match_clr_i = 1'b0;
  logic       match_ie_i = 1'b0;
  logic [7:0] count_o;
  logic       ovf_flag_o, match_flag_o, match_irq_o, wave_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tmr8_ctc dut_i (
    .clk_i, .rst_ni, .tick_i, .wave_mode_i, .out_mode_i, .cmp_val_i,
    .force_i, .cnt_wr_i, .cnt_wdata_i, .ovf_clr_i, .match_clr_i,
    .match_ie_i, .count_o, .ovf_flag_o, .match_flag_o, .match_irq_o, .wave_o
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load(logic [7:0] v);
    cnt_wr_i = 1'b1; cnt_wdata_i = v;
    step();
    cnt_wr_i = 1'b0;
  endtask

  task automatic ticks(int n);
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) step();
    tick_i = 1'b0;
  endtask

  task automatic clear_flags();
    ovf_clr_i = 1'b1; match_clr_i = 1'b1;
    step();
    ovf_clr_i = 1'b0; match_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "count", count_o, 0);
    chk("R1", "ovf", ovf_flag_o, 0);
    chk("R1", "match", match_flag_o, 0);
    chk("R1", "wave", wave_o, 0);
  endtask

  task automatic t_normal();
    wave_mode_i = 3'd0; cmp_val_i = 8'h10;
    clear_flags();
    load(8'hFD);
    chk("R9", "load value", count_o, 8'hFD);
    ticks(1);
    chk("R2", "increment", count_o, 8'hFE);
    step();
    chk("R2", "hold without tick", count_o, 8'hFE);
    ticks(1);
    chk("R3", "no ovf before wrap", ovf_flag_o, 0);
    ticks(1);
    chk("R2", "wrap to zero", count_o, 8'h00);
    chk("R3", "ovf on wrap", ovf_flag_o, 1);
    step(); step();
    chk("R3", "ovf sticky", ovf_flag_o, 1);
    ovf_clr_i = 1'b1; step(); ovf_clr_i = 1'b0;
    chk("R3", "ovf cleared", ovf_flag_o, 0);
    load(8'hFF);
    ovf_clr_i = 1'b1; ticks(1); ovf_clr_i = 1'b0;
    chk("R3", "set wins over clear", ovf_flag_o, 1);
    // mode 5 acts as free-running
    wave_mode_i = 3'd5; cmp_val_i = 8'h01;
    clear_flags();
    load(8'h00);
    ticks(2);
    chk("R2", "no clear at compare in mode 5", count_o, 8'h02);
    chk("R5", "match flag in free-running", match_flag_o, 1);
  endtask

  task automatic t_ctc();
    wave_mode_i = 3'd2; cmp_val_i = 8'h03; match_ie_i = 1'b0;
    clear_flags();
    load(8'h00);
    ticks(3);
    chk("R4", "reached top", count_o, 8'h03);
    chk("R5", "no flag before hit", match_flag_o, 0);
    ticks(1);
    chk("R4", "cleared after top", count_o, 8'h00);
    chk("R5", "flag at hit", match_flag_o, 1);
    chk("R5", "irq masked", match_irq_o, 0);
    chk("R3", "no ovf in compare clear", ovf_flag_o, 0);
    match_ie_i = 1'b1; #1;
    chk("R5", "irq enabled", match_irq_o, 1);
    match_clr_i = 1'b1; step(); match_clr_i = 1'b0;
    chk("R5", "flag cleared", match_flag_o, 0);
    chk("R5", "irq dropped", match_irq_o, 0);
    ticks(3);
    match_clr_i = 1'b1; ticks(1); match_clr_i = 1'b0;
    chk("R5", "set wins over clear", match_flag_o, 1);
    match_ie_i = 1'b0;
  endtask

  task automatic t_write();
    wave_mode_i = 3'd2; cmp_val_i = 8'h05;
    clear_flags();
    load(8'h05);
    ticks(1);
    chk("R9", "suppressed hit counts on", count_o, 8'h06);
    chk("R9", "suppressed hit no flag", match_flag_o, 0);
    cnt_wr_i = 1'b1; cnt_wdata_i = 8'h07; tick_i = 1'b1;
    step();
    cnt_wr_i = 1'b0; tick_i = 1'b0;
    chk("R9", "load beats tick", count_o, 8'h07);
  endtask

  task automatic t_out();
    wave_mode_i = 3'd2; cmp_val_i = 8'h01; out_mode_i = 2'd1;
    load(8'h00);
    ticks(1);
    chk("R7", "code not applied before hit", wave_o, 0);
    ticks(1);
    chk("R6", "toggle high", wave_o, 1);
    ticks(2);
    chk("R6", "toggle low", wave_o, 0);
    out_mode_i = 2'd3;
    ticks(1);
    chk("R7", "set pending", wave_o, 0);
    ticks(1);
    chk("R6", "set at hit", wave_o, 1);
    out_mode_i = 2'd2;
    ticks(2);
    chk("R6", "clear at hit", wave_o, 0);
    out_mode_i = 2'd3;
    ticks(2);
    chk("R6", "set again", wave_o, 1);
    out_mode_i = 2'd0;
    ticks(1);
    chk("R7", "disconnect pending", wave_o, 1);
    ticks(1);
    chk("R6", "disconnected", wave_o, 0);
  endtask

  task automatic t_force();
    wave_mode_i = 3'd2; cmp_val_i = 8'h20;
    load(8'h20);
    clear_flags();
    out_mode_i = 2'd3; force_i = 1'b1; step(); force_i = 1'b0;
    chk("R8", "force set", wave_o, 1);
    chk("R8", "force no flag", match_flag_o, 0);
    chk("R8", "force no clear", count_o, 8'h20);
    out_mode_i = 2'd1; force_i = 1'b1; step(); force_i = 1'b0;
    chk("R8", "force toggle low", wave_o, 0);
    force_i = 1'b1; step(); force_i = 1'b0;
    chk("R8", "force toggle high", wave_o, 1);
    out_mode_i = 2'd2; force_i = 1'b1; step(); force_i = 1'b0;
    chk("R8", "force clear", wave_o, 0);
    chk("R8", "flag still clear", match_flag_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_normal();
    t_ctc();
    t_write();
    t_out();
    t_force();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule